// File: doc/BRIEF.md
# Start-stop serial transmitter

This block sends bytes over a single serial line using start-stop framing. The host writes bytes into a small transmit buffer through a one-cycle write strobe. A shift stage takes each byte and sends it as a frame: a start bit (0), then 7 or 8 data bits in the chosen order, then one stop bit (1). Bit timing comes from an external bit-clock strobe. Only its falling edges move the line. The shift stage then waits for the next falling edge after it is loaded, so a frame always starts on a bit boundary.

Two status flags tell the host where its data is. The buffer-empty flag reads 1 when no byte is waiting behind the shift stage. The shift-empty flag reads 1 when no frame is loaded or being sent. Each flag also raises a one-cycle interrupt strobe when it turns on. The buffer holds either one entry or a parameterised number of entries, selected by an input. When a byte is waiting at the end of a stop bit, the next frame follows with no idle bit in between. Clearing the mode enable aborts any frame in progress, empties the buffer and returns the line to 1.

Top module: `sst_tx`

## Requirements
- R1: While `async_en` is 0, the line `txd` is 1 and both `buf_empty` and `shf_empty` are 1. Writes are ignored. A frame in progress is aborted, and the line is 1 from the cycle after `async_en` falls. After `async_en` returns to 1, the line stays 1 until a new write.
- R2: A write while enabled, with the shift stage idle and the buffer empty, loads the byte straight into the shift stage. `shf_empty` reads 0 in the cycle after the write, and `buf_empty` stays 1. Nothing else moves `txd` off 1 until the next falling strobe (`bit_edge`=1 together with `bit_edge_fall`=1): a rising strobe (`bit_edge`=1, `bit_edge_fall`=0) does not, and neither does a cycle with no strobe. The start bit 0 appears on `txd` in the cycle after that falling strobe.
- R3: Each further falling strobe moves the line to the next bit, one cycle after the strobe. The data bits come first, then a single stop bit of value 1 directly after the last data bit.
- R4: `len8`=1 gives 8 data bits and `len8`=0 gives 7 data bits per frame. `len8` and `lsb_first` are sampled in the cycle the byte enters the shift stage. Later changes do not alter that frame.
- R5: With `lsb_first`=1 the data bits leave as bit 0 upward. With `lsb_first`=0 they leave as bit 7 downward. A 7-bit frame therefore carries bits 0..6 in the first order and bits 7..1 in the second.
- R6: A write while the shift stage holds a frame goes into the buffer, and `buf_empty` reads 0 in the next cycle. The buffer holds `FIFO_DEPTH` entries when `fifo_en`=1 and one entry when `fifo_en`=0. A write to a full buffer is dropped and is never sent.
- R7: At the falling strobe that ends a stop bit, if the buffer is not empty, its oldest byte is loaded and the start bit is driven at once, with no idle bit. `shf_empty` stays 0. `buf_empty` turns 1 if that was the last buffered byte. Bytes leave in write order.
- R8: If the buffer is empty at the falling strobe that ends a stop bit, `shf_empty` turns 1 in the next cycle and `txd` stays 1.
- R9: `buf_irq` and `shf_irq` are each 1 for exactly one cycle: the first cycle in which the matching flag reads 1 after having read 0. They give no pulse when reset is released.
- R10: After reset, `txd` is 1, both flags are 1 and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| async_en | input | 1 | Mode enable; 0 aborts and holds the line idle |
| fifo_en | input | 1 | 1: buffer of FIFO_DEPTH entries, 0: single entry |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| bit_edge | input | 1 | One-cycle strobe marking a bit-clock edge |
| bit_edge_fall | input | 1 | Qualifies `bit_edge` as a falling edge |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| txd | output | 1 | Serial line, idle 1 |
| buf_empty | output | 1 | No byte waiting in the buffer |
| shf_empty | output | 1 | Shift stage holds no frame |
| buf_irq | output | 1 | Pulse when `buf_empty` turns on |
| shf_irq | output | 1 | Pulse when `shf_empty` turns on |

## Verification
The bench first walks a table of bytes covering both frame lengths and both bit orders. For each byte it flips the configuration right after the write: a design that did not latch the configuration at load would change length or order in mid-frame. It sends rising strobes between writes and launch, and a design that moved on those would start early. Back-to-back frames are checked for a start bit right on the stop-ending edge, where a design that inserts an idle bit would show 1. A write into a full single-entry buffer is followed by one more edge with the line expected idle, which exposes a design that overwrote or kept the dropped byte. A mid-frame abort must show the line at 1 and both flags with their pulses at once, and no frame may start after the mode is enabled again.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    FR_IDLE  = 3'd0,
    FR_ARMED = 3'd1,
    FR_START = 3'd2,
    FR_DATA  = 3'd3,
    FR_STOP  = 3'd4
  } fr_state_e;
endpackage

// File: rtl/sst_rst_sync.sv
module sst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sst_fifo.sv
module sst_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             one_slot_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    cap;
  logic             full, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    cap     = one_slot_i ? CW'(1) : CW'(DEPTH);
    full    = (cnt_q >= cap);
    empty_o = (cnt_q == '0);
    do_push = push_i && !full && !flush_i;
    do_pop  = pop_i && !empty_o && !flush_i;
    rd_d    = rd_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    if (flush_i) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];

  // R6: a write into a full buffer leaves the occupancy unchanged
  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q)));

  // R1: a flush empties the buffer on the next cycle
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);
endmodule

// File: rtl/sst_framer.sv
module sst_framer
  import sst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              fall_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  input  logic              ld_len8_i,
  input  logic              ld_lsb_i,
  output logic              ready_o,
  output logic              idle_o,
  output logic              txd_o
);
  fr_state_e         st_q, st_d;
  logic [3:0]        pos_q, pos_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              len8_q, len8_d;
  logic              lsb_q, lsb_d;
  logic [3:0]        last_pos;
  logic              stop_end;
  logic              load_ok;
  logic [2:0]        bit_idx;

  always_comb begin
    last_pos = len8_q ? 4'd8 : 4'd7;
    stop_end = (st_q == FR_STOP) && fall_i;
    ready_o  = !abort_i && ((st_q == FR_IDLE) || stop_end);
    load_ok  = load_i && ready_o;
    idle_o   = (st_q == FR_IDLE);
  end

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    sh_d   = sh_q;
    len8_d = len8_q;
    lsb_d  = lsb_q;
    if (abort_i) begin
      st_d  = FR_IDLE;
      pos_d = '0;
    end else begin
      if (load_ok) begin
        sh_d   = ld_data_i;
        len8_d = ld_len8_i;
        lsb_d  = ld_lsb_i;
      end
      case (st_q)
        FR_IDLE:  if (load_ok) st_d = FR_ARMED;
        FR_ARMED: if (fall_i)  st_d = FR_START;
        FR_START: if (fall_i) begin
          st_d  = FR_DATA;
          pos_d = 4'd1;
        end
        FR_DATA:  if (fall_i) begin
          if (pos_q == last_pos) st_d = FR_STOP;
          else                   pos_d = pos_q + 4'd1;
        end
        FR_STOP:  if (fall_i) st_d = load_ok ? FR_START : FR_IDLE;
        default:  st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      pos_q  <= '0;
      sh_q   <= '0;
      len8_q <= 1'b1;
      lsb_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      sh_q   <= sh_d;
      len8_q <= len8_d;
      lsb_q  <= lsb_d;
    end
  end

  always_comb begin
    bit_idx = lsb_q ? 3'(pos_q - 4'd1) : 3'(4'd8 - pos_q);
    case (st_q)
      FR_START: txd_o = 1'b0;
      FR_DATA:  txd_o = sh_q[bit_idx];
      default:  txd_o = 1'b1;
    endcase
  end

  // R2: an armed frame waits for a falling strobe with the line high
  a_r2_wait_for_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_ARMED && !fall_i && !abort_i) |=> (st_q == FR_ARMED && txd_o));

  // R3: the bit after the last data bit is a stop bit
  a_r3_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_DATA && fall_i && !abort_i && pos_q == last_pos) |=> txd_o);

  // R7: a load at the end of a stop bit starts the next frame at once
  a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_end && load_i && !abort_i) |=> (!txd_o && !idle_o));

  // R8: a stop bit with nothing to load returns to idle
  a_r8_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_end && !load_i && !abort_i) |=> (idle_o && txd_o));
endmodule

// File: rtl/sst_flag_pulse.sv
module sst_flag_pulse #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = flag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign pulse_o[i] = flag_i[i] && !prev_q[i];

    // R9: a pulse lasts one cycle while its flag stays on
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o[i] && flag_i[i]) |=> !pulse_o[i]);
  end
endmodule

// File: rtl/sst_tx.sv
module sst_tx
  import sst_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_en,
  input  logic              fifo_en,
  input  logic              len8,
  input  logic              lsb_first,
  input  logic              bit_edge,
  input  logic              bit_edge_fall,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              shf_empty,
  output logic              buf_irq,
  output logic              shf_irq
);
  logic              rst_n_s;
  logic              abort, fall, wr_ok, direct;
  logic              fr_ready, fr_idle, fr_load;
  logic              fifo_push, fifo_pop, fifo_empty;
  logic [BYTE_W-1:0] fifo_rdata, ld_data;
  logic [1:0]        flags, pulses;

  sst_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    abort     = !async_en;
    fall      = bit_edge && bit_edge_fall;
    wr_ok     = async_en && wr_en;
    direct    = wr_ok && fr_idle && fifo_empty;
    fr_load   = fr_ready && (!fifo_empty || direct);
    fifo_pop  = fr_ready && !fifo_empty;
    fifo_push = wr_ok && !direct;
    ld_data   = fifo_empty ? wr_data : fifo_rdata;
  end

  sst_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .flush_i    (abort),
    .one_slot_i (!fifo_en),
    .push_i     (fifo_push),
    .wdata_i    (wr_data),
    .pop_i      (fifo_pop),
    .rdata_o    (fifo_rdata),
    .empty_o    (fifo_empty)
  );

  sst_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .abort_i   (abort),
    .fall_i    (fall),
    .load_i    (fr_load),
    .ld_data_i (ld_data),
    .ld_len8_i (len8),
    .ld_lsb_i  (lsb_first),
    .ready_o   (fr_ready),
    .idle_o    (fr_idle),
    .txd_o     (txd)
  );

  assign flags = {fr_idle, fifo_empty};

  sst_flag_pulse #(.N(2)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .flag_i  (flags),
    .pulse_o (pulses)
  );

  assign buf_empty = fifo_empty;
  assign shf_empty = fr_idle;
  assign buf_irq   = pulses[0];
  assign shf_irq   = pulses[1];

  // R1: disabling the mode idles the line and empties both stages
  a_r1_disable_idles: assert property (@(posedge clk) disable iff (!rst_n_s)
    !async_en |=> (txd && shf_empty && buf_empty));

  // R2: a direct write fills the shift stage, not the buffer
  a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n_s)
    (async_en && wr_en && shf_empty && buf_empty) |=> (!shf_empty && buf_empty && txd));

  // R6: a write while a frame is held lands in the buffer
  a_r6_write_buffers: assert property (@(posedge clk) disable iff (!rst_n_s)
    (async_en && wr_en && !shf_empty && buf_empty) |=> !buf_empty);

  // R9: an interrupt pulse only accompanies its flag
  a_r9_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n_s)
    (buf_irq |-> buf_empty) and (shf_irq |-> shf_empty));

  // R1: the line is low only while a frame is held
  a_r1_low_needs_frame: assert property (@(posedge clk) disable iff (!rst_n_s)
    !txd |-> !shf_empty);
endmodule

// File: tb/sst_tx_tb_top.sv
`timescale 1ns/1ps
module sst_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       async_en, fifo_en, len8, lsb_first;
  logic       bit_edge, bit_edge_fall, wr_en;
  logic [7:0] wr_data;
  logic       txd, buf_empty, shf_empty, buf_irq, shf_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sst_tx #(.FIFO_DEPTH(4)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .async_en      (async_en),
    .fifo_en       (fifo_en),
    .len8          (len8),
    .lsb_first     (lsb_first),
    .bit_edge      (bit_edge),
    .bit_edge_fall (bit_edge_fall),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .txd           (txd),
    .buf_empty     (buf_empty),
    .shf_empty     (shf_empty),
    .buf_irq       (buf_irq),
    .shf_irq       (shf_irq)
  );

  typedef struct packed {
    logic [7:0] data;
    logic       l8;
    logic       lsb;
    logic [3:0] n_data;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{data: 8'hA5, l8: 1'b1, lsb: 1'b1, n_data: 4'd8},
    '{data: 8'hA5, l8: 1'b1, lsb: 1'b0, n_data: 4'd8},
    '{data: 8'h3C, l8: 1'b0, lsb: 1'b1, n_data: 4'd7},
    '{data: 8'h3C, l8: 1'b0, lsb: 1'b0, n_data: 4'd7},
    '{data: 8'h01, l8: 1'b1, lsb: 1'b0, n_data: 4'd8},
    '{data: 8'h80, l8: 1'b0, lsb: 1'b1, n_data: 4'd7}
  };

  function automatic logic exp_bit(input logic [7:0] d, input logic lsb, input int k);
    return lsb ? d[k-1] : d[8-k];
  endfunction

  task automatic check(input logic got, input logic exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", what, got, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic fall_edge();
    bit_edge = 1'b1; bit_edge_fall = 1'b1;
    @(negedge clk);
    bit_edge = 1'b0; bit_edge_fall = 1'b0;
  endtask

  task automatic rise_edge();
    bit_edge = 1'b1; bit_edge_fall = 1'b0;
    @(negedge clk);
    bit_edge = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame_body(input logic [7:0] d, input logic lsb, input int n, input string tag);
    for (int k = 1; k <= n; k++) begin
      fall_edge();
      check(txd, exp_bit(d, lsb, k), $sformatf("R3 R4 R5 %s data bit %0d", tag, k));
    end
    fall_edge();
    check(txd, 1'b1, $sformatf("R3 %s stop bit", tag));
  endtask

  task automatic dump_summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      dump_summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; async_en = 1'b0; fifo_en = 1'b1; len8 = 1'b1; lsb_first = 1'b1;
    bit_edge = 1'b0; bit_edge_fall = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check(txd, 1'b1, "R10 txd after reset");
    check(buf_empty, 1'b1, "R10 buf_empty after reset");
    check(shf_empty, 1'b1, "R10 shf_empty after reset");
    check(buf_irq, 1'b0, "R10 buf_irq after reset");
    check(shf_irq, 1'b0, "R10 shf_irq after reset");

    // R1 enabling holds the line idle
    async_en = 1'b1;
    idle_cycle();
    fall_edge();
    check(txd, 1'b1, "R1 idle line after enable");

    // table walk: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      len8 = VECS[v].l8; lsb_first = VECS[v].lsb;
      write(VECS[v].data);
      len8 = ~VECS[v].l8; lsb_first = ~VECS[v].lsb;
      check(shf_empty, 1'b0, $sformatf("R2 vec%0d shf_empty after write", v));
      check(buf_empty, 1'b1, $sformatf("R2 vec%0d buf_empty after write", v));
      rise_edge();
      check(txd, 1'b1, $sformatf("R2 vec%0d line after rising strobe", v));
      idle_cycle();
      check(txd, 1'b1, $sformatf("R2 vec%0d line before falling strobe", v));
      fall_edge();
      check(txd, 1'b0, $sformatf("R2 vec%0d start bit", v));
      frame_body(VECS[v].data, VECS[v].lsb, int'(VECS[v].n_data), $sformatf("vec%0d", v));
      fall_edge();
      check(shf_empty, 1'b1, $sformatf("R8 vec%0d shf_empty after stop", v));
      check(shf_irq, 1'b1, $sformatf("R9 vec%0d shf_irq pulse", v));
      check(txd, 1'b1, $sformatf("R8 vec%0d line idle after stop", v));
      idle_cycle();
      check(shf_irq, 1'b0, $sformatf("R9 vec%0d shf_irq one cycle", v));
    end

    // back-to-back frames through the buffer: R6 R7 R9
    fifo_en = 1'b1; len8 = 1'b1; lsb_first = 1'b1;
    write(8'h5A);
    write(8'hC3);
    check(buf_empty, 1'b0, "R6 buf_empty after buffered write");
    write(8'h0F);
    fall_edge();
    check(txd, 1'b0, "R2 b2b first start bit");
    frame_body(8'h5A, 1'b1, 8, "b2b first");
    fall_edge();
    check(txd, 1'b0, "R7 second start without idle bit");
    check(shf_empty, 1'b0, "R7 shf_empty stays 0");
    check(buf_empty, 1'b0, "R7 third byte still buffered");
    frame_body(8'hC3, 1'b1, 8, "b2b second");
    fall_edge();
    check(txd, 1'b0, "R7 third start without idle bit");
    check(buf_empty, 1'b1, "R7 buf_empty after last byte leaves");
    check(buf_irq, 1'b1, "R9 buf_irq pulse");
    idle_cycle();
    check(buf_irq, 1'b0, "R9 buf_irq one cycle");
    frame_body(8'h0F, 1'b1, 8, "b2b third");
    fall_edge();
    check(shf_empty, 1'b1, "R8 idle after third frame");

    // single-entry buffer drops a write when full: R6
    fifo_en = 1'b0;
    write(8'h11);
    write(8'h22);
    write(8'h33);
    check(buf_empty, 1'b0, "R6 single entry holds a byte");
    fall_edge();
    check(txd, 1'b0, "R6 first start");
    frame_body(8'h11, 1'b1, 8, "single first");
    fall_edge();
    check(txd, 1'b0, "R7 second start single entry");
    check(buf_empty, 1'b1, "R6 buffer empty after one byte");
    frame_body(8'h22, 1'b1, 8, "single second");
    fall_edge();
    check(shf_empty, 1'b1, "R6 dropped byte not loaded");
    fall_edge();
    check(txd, 1'b1, "R6 dropped byte never sent");
    check(shf_empty, 1'b1, "R6 shift stage still empty");

    // abort in mid-frame: R1 R9
    fifo_en = 1'b1;
    write(8'h00);
    write(8'hAA);
    fall_edge();
    check(txd, 1'b0, "R1 start before abort");
    fall_edge();
    check(txd, 1'b0, "R1 data bit before abort");
    async_en = 1'b0;
    idle_cycle();
    check(txd, 1'b1, "R1 line high after abort");
    check(shf_empty, 1'b1, "R1 shf_empty after abort");
    check(buf_empty, 1'b1, "R1 buf_empty after abort");
    check(shf_irq, 1'b1, "R9 shf_irq on abort");
    check(buf_irq, 1'b1, "R9 buf_irq on abort");
    write(8'h55);
    check(shf_empty, 1'b1, "R1 write ignored while disabled shf");
    check(buf_empty, 1'b1, "R1 write ignored while disabled buf");
    async_en = 1'b1;
    idle_cycle();
    fall_edge();
    check(txd, 1'b1, "R1 no frame after re-enable");
    fall_edge();
    check(txd, 1'b1, "R1 line still idle");

    done = 1'b1;
    dump_summary();
    $finish;
  end
endmodule